// File: doc/BRIEF.md
# Multi-Set Frame Buffer Address Sequencer

This block produces the memory start address of every line of a video frame that sits in one of several buffer sets. Each set is described by a base address, a buffer count, the address step from one buffer to the next, the address step from one line to the next, and a line count (height). When a frame is requested, the block picks the buffer for that frame. It presents the first line address and steps through the remaining lines as a downstream reader acknowledges each one. It then pulses an end-of-frame strobe and moves its position on to the next buffer.

Two walking orders exist. In single-set order, only the chosen starting set is used and its buffers are cycled. In all-sets order, the sets are read one after another, starting at the chosen set and wrapping after the last active set. Each set begins at its first buffer. The number of active sets is requested at an input. A request of zero, or one larger than the build-time maximum, falls back to a single set. A separate output holds the base of the most recently started buffer. It reads as all ones until the first frame has begun. The per-set parameters are expected to stay constant while their set is being walked.

Top module: `fsq_frame_seq`

## Requirements
- R1: After reset, `line_valid` and `frame_done` are 0 and `last_base` is all ones.
- R2: A `frame_start` pulse while no frame is in progress makes `line_valid` 1 in the following cycle, with `line_addr` equal to the chosen buffer's base. A `frame_start` that arrives while a frame is in progress is ignored and leaves no frame queued.
- R3: Each cycle in which `line_done` is 1 while `line_valid` is 1 and lines remain moves `line_addr` on by the set's line step in the next cycle. A frame presents exactly height line addresses.
- R4: The `line_done` of the last line drops `line_valid` and raises `frame_done` for exactly one cycle in the next cycle. A set with height 0 presents no line, and `frame_done` is 1 in the cycle after `frame_start`.
- R5: Buffer k of a set (k counting from 0) starts at the set base plus k times the buffer step. After the last buffer, the index returns to 0. A set whose buffer count is 0 or 1 always uses its base, and its buffer step has no effect.
- R6: With `mode_all_sets` = 0 only the starting set is read. If `start_set` differs from the set last used, the next frame is buffer 0 of the new set.
- R7: With `mode_all_sets` = 1, after the last buffer of set s the next frame is buffer 0 of set s+1. After the last active set, the order wraps to set 0.
- R8: The active set count equals `req_sets` when it lies in 1..N_SETS and is 1 otherwise. A `start_set` not below the active count selects set 0.
- R9: The first frame after reset is buffer 0 of the starting set.
- R10: `last_base` takes the base of each frame's buffer in the cycle after its `frame_start` is accepted, and holds it until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_all_sets | input | 1 | 0: single-set order, 1: all-sets order |
| start_set | input | SETW (2) | Index of the starting set |
| req_sets | input | REQW (7) | Requested number of active sets |
| set_base | input | N_SETS*AW (128) | Base address per set, set i at bits [i*AW +: AW] |
| set_nbuf | input | N_SETS*NBW (32) | Buffer count per set |
| set_bstep | input | N_SETS*AW (128) | Address step between buffers per set |
| set_lstep | input | N_SETS*AW (128) | Address step between lines per set |
| set_height | input | N_SETS*HW (68) | Lines per frame per set |
| frame_start | input | 1 | Request for one frame |
| line_done | input | 1 | Current line address consumed |
| line_addr | output | AW (32) | Start address of the current line |
| line_valid | output | 1 | `line_addr` holds a line of the current frame |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |
| last_base | output | AW (32) | Base of the buffer last started |

## Verification
The bench goes after the wrap points: the last buffer of a set, the last active set in all-sets order, and sets whose buffer count is 0 or 1 while their buffer step is nonzero. A design that gets these wrong reads past the set or adds a stray step to the base. It drives illegal set counts (0 and above the maximum) and a starting set beyond the active count. A design without the fallback would walk unconfigured sets. A zero-height set checks that the end-of-frame pulse still comes and that no line leaks out. Starts that arrive during a frame must be dropped rather than queued, and a change of starting set between frames must restart at buffer 0.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic {
        FSQ_IDLE  = 1'b0,
        FSQ_LINES = 1'b1
    } fsq_state_e;

endpackage

// File: rtl/fsq_set_mux.sv
module fsq_set_mux #(
    parameter int N_SETS = 4,
    parameter int AW     = 32,
    parameter int NBW    = 8,
    parameter int HW     = 17,
    parameter int SETW   = 2
) (
    input  logic [SETW-1:0]      idx,
    input  logic [N_SETS*AW-1:0] base_bus,
    input  logic [N_SETS*NBW-1:0] nbuf_bus,
    input  logic [N_SETS*AW-1:0] bstep_bus,
    input  logic [N_SETS*AW-1:0] lstep_bus,
    input  logic [N_SETS*HW-1:0] height_bus,
    output logic [AW-1:0]        base_o,
    output logic [NBW-1:0]       nbuf_o,
    output logic [AW-1:0]        bstep_o,
    output logic [AW-1:0]        lstep_o,
    output logic [HW-1:0]        height_o
);

    always_comb begin
        base_o   = '0;
        nbuf_o   = '0;
        bstep_o  = '0;
        lstep_o  = '0;
        height_o = '0;
        for (int i = 0; i < N_SETS; i++) begin
            if (idx == SETW'(i)) begin
                base_o   = base_bus[i*AW +: AW];
                nbuf_o   = nbuf_bus[i*NBW +: NBW];
                bstep_o  = bstep_bus[i*AW +: AW];
                lstep_o  = lstep_bus[i*AW +: AW];
                height_o = height_bus[i*HW +: HW];
            end
        end
    end

endmodule

// File: rtl/fsq_advance.sv
module fsq_advance #(
    parameter int SETW = 2,
    parameter int CNTW = 3,
    parameter int NBW  = 8,
    parameter int AW   = 32
) (
    input  logic            mode_all,
    input  logic [SETW-1:0] set_i,
    input  logic [NBW-1:0]  bidx_i,
    input  logic [AW-1:0]   boff_i,
    input  logic [NBW-1:0]  nbuf,
    input  logic [AW-1:0]   bstep,
    input  logic [CNTW-1:0] active,
    output logic [SETW-1:0] set_o,
    output logic [NBW-1:0]  bidx_o,
    output logic [AW-1:0]   boff_o
);

    logic [NBW:0]  bidx_inc;
    logic [CNTW:0] set_inc;
    logic          last_buf;

    always_comb begin
        bidx_inc = (NBW+1)'(bidx_i) + (NBW+1)'(1);
        set_inc  = (CNTW+1)'(set_i) + (CNTW+1)'(1);
        last_buf = (nbuf <= NBW'(1)) || (bidx_inc >= {1'b0, nbuf});
        if (last_buf) begin
            bidx_o = '0;
            boff_o = '0;
            if (mode_all) begin
                set_o = (set_inc >= {1'b0, active}) ? '0 : set_inc[SETW-1:0];
            end else begin
                set_o = set_i;
            end
        end else begin
            bidx_o = bidx_inc[NBW-1:0];
            boff_o = boff_i + bstep;
            set_o  = set_i;
        end
    end

endmodule

// File: rtl/fsq_frame_seq.sv
module fsq_frame_seq
    import fsq_pkg::*;
#(
    parameter int N_SETS = 4,
    parameter int AW     = 32,
    parameter int NBW    = 8,
    parameter int HW     = 17,
    parameter int REQW   = 7,
    localparam int SETW  = (N_SETS > 1) ? $clog2(N_SETS) : 1,
    localparam int CNTW  = $clog2(N_SETS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_all_sets,
    input  logic [SETW-1:0]        start_set,
    input  logic [REQW-1:0]        req_sets,
    input  logic [N_SETS*AW-1:0]   set_base,
    input  logic [N_SETS*NBW-1:0]  set_nbuf,
    input  logic [N_SETS*AW-1:0]   set_bstep,
    input  logic [N_SETS*AW-1:0]   set_lstep,
    input  logic [N_SETS*HW-1:0]   set_height,
    input  logic                   frame_start,
    input  logic                   line_done,
    output logic [AW-1:0]          line_addr,
    output logic                   line_valid,
    output logic                   frame_done,
    output logic [AW-1:0]          last_base
);

    typedef struct packed {
        fsq_state_e      st;
        logic            fresh;
        logic [SETW-1:0] set;
        logic [NBW-1:0]  bidx;
        logic [AW-1:0]   boff;
        logic [HW-1:0]   rem;
        logic [AW-1:0]   addr;
        logic            valid;
        logic            done;
        logic [AW-1:0]   last;
    } seq_t;

    seq_t q, d;

    logic [CNTW-1:0] active_d;
    logic [SETW-1:0] start_ok_d;
    logic            reselect_d;
    logic            idle_d;
    logic [SETW-1:0] sel_set_d;
    logic [NBW-1:0]  sel_bidx_d;
    logic [AW-1:0]   sel_boff_d;
    logic [SETW-1:0] mux_idx_d;
    logic [AW-1:0]   frame_base_d;

    logic [AW-1:0]   m_base, m_bstep, m_lstep;
    logic [NBW-1:0]  m_nbuf;
    logic [HW-1:0]   m_height;

    logic [SETW-1:0] adv_set_in, adv_set_out;
    logic [NBW-1:0]  adv_bidx_in, adv_bidx_out;
    logic [AW-1:0]   adv_boff_in, adv_boff_out;

    // Selection of the set and buffer for a frame about to start
    always_comb begin
        idle_d = (q.st == FSQ_IDLE);
        if (req_sets != '0 && req_sets <= REQW'(N_SETS)) begin
            active_d = CNTW'(req_sets);
        end else begin
            active_d = CNTW'(1);
        end
        start_ok_d = (CNTW'(start_set) < active_d) ? start_set : '0;
        reselect_d = q.fresh
                  || (CNTW'(q.set) >= active_d)
                  || (!mode_all_sets && (start_ok_d != q.set));
        sel_set_d  = reselect_d ? start_ok_d : q.set;
        sel_bidx_d = reselect_d ? '0 : q.bidx;
        sel_boff_d = reselect_d ? '0 : q.boff;
        mux_idx_d  = idle_d ? sel_set_d : q.set;
        adv_set_in  = idle_d ? sel_set_d  : q.set;
        adv_bidx_in = idle_d ? sel_bidx_d : q.bidx;
        adv_boff_in = idle_d ? sel_boff_d : q.boff;
        frame_base_d = m_base + sel_boff_d;
    end

    fsq_set_mux #(
        .N_SETS(N_SETS), .AW(AW), .NBW(NBW), .HW(HW), .SETW(SETW)
    ) u_mux (
        .idx        (mux_idx_d),
        .base_bus   (set_base),
        .nbuf_bus   (set_nbuf),
        .bstep_bus  (set_bstep),
        .lstep_bus  (set_lstep),
        .height_bus (set_height),
        .base_o     (m_base),
        .nbuf_o     (m_nbuf),
        .bstep_o    (m_bstep),
        .lstep_o    (m_lstep),
        .height_o   (m_height)
    );

    fsq_advance #(
        .SETW(SETW), .CNTW(CNTW), .NBW(NBW), .AW(AW)
    ) u_adv (
        .mode_all (mode_all_sets),
        .set_i    (adv_set_in),
        .bidx_i   (adv_bidx_in),
        .boff_i   (adv_boff_in),
        .nbuf     (m_nbuf),
        .bstep    (m_bstep),
        .active   (active_d),
        .set_o    (adv_set_out),
        .bidx_o   (adv_bidx_out),
        .boff_o   (adv_boff_out)
    );

    // Next-state computation
    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (idle_d && frame_start) begin
            d.fresh = 1'b0;
            d.last  = frame_base_d;
            d.set   = sel_set_d;
            d.bidx  = sel_bidx_d;
            d.boff  = sel_boff_d;
            if (m_height == '0) begin
                d.done = 1'b1;
                d.set  = adv_set_out;
                d.bidx = adv_bidx_out;
                d.boff = adv_boff_out;
            end else begin
                d.st    = FSQ_LINES;
                d.valid = 1'b1;
                d.addr  = frame_base_d;
                d.rem   = m_height;
            end
        end else if (!idle_d && line_done) begin
            if (q.rem == HW'(1)) begin
                d.st    = FSQ_IDLE;
                d.valid = 1'b0;
                d.done  = 1'b1;
                d.set   = adv_set_out;
                d.bidx  = adv_bidx_out;
                d.boff  = adv_boff_out;
            end else begin
                d.rem  = q.rem - HW'(1);
                d.addr = q.addr + m_lstep;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= FSQ_IDLE;
            q.fresh <= 1'b1;
            q.last  <= '1;
        end else begin
            q <= d;
        end
    end

    assign line_addr  = q.addr;
    assign line_valid = q.valid;
    assign frame_done = q.done;
    assign last_base  = q.last;

    // Until a frame has begun, the last-base register keeps its reset value
    p_unread_all_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.fresh |-> (last_base == '1));

    // An accepted start of a non-empty set shows its base on both outputs
    p_start_presents_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_d && frame_start && m_height != '0) |=> (line_valid && line_addr == last_base));

    // Consecutive lines of one frame differ by the line step
    p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(line_valid && line_done) && line_valid)
            |-> (line_addr == $past(line_addr) + $past(m_lstep)));

    // The end-of-frame strobe lasts one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // No line is presented while the end-of-frame strobe is up
    p_done_no_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !line_valid);

    // A new frame's first line is the base recorded for it
    p_first_line_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> (last_base == line_addr));

endmodule

// File: tb/tb_fsq_frame_seq.sv
module tb_fsq_frame_seq;

    localparam int N_SETS = 4;
    localparam int AW     = 32;
    localparam int NBW    = 8;
    localparam int HW     = 17;
    localparam int REQW   = 7;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  mode_all_sets = 1'b0;
    logic [1:0]            start_set = '0;
    logic [REQW-1:0]       req_sets = '0;
    logic [N_SETS*AW-1:0]  set_base;
    logic [N_SETS*NBW-1:0] set_nbuf;
    logic [N_SETS*AW-1:0]  set_bstep;
    logic [N_SETS*AW-1:0]  set_lstep;
    logic [N_SETS*HW-1:0]  set_height;
    logic                  frame_start = 1'b0;
    logic                  line_done = 1'b0;
    logic [AW-1:0]         line_addr;
    logic                  line_valid;
    logic                  frame_done;
    logic [AW-1:0]         last_base;

    logic [31:0] b_base [N_SETS];
    logic [31:0] b_nbuf [N_SETS];
    logic [31:0] b_bstep[N_SETS];
    logic [31:0] b_lstep[N_SETS];
    logic [31:0] b_h    [N_SETS];

    int compared = 0;
    int mismatched = 0;
    bit compare_on = 1'b0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N_SETS; i++) begin
            set_base[i*AW +: AW]   = b_base[i];
            set_nbuf[i*NBW +: NBW] = b_nbuf[i][NBW-1:0];
            set_bstep[i*AW +: AW]  = b_bstep[i];
            set_lstep[i*AW +: AW]  = b_lstep[i];
            set_height[i*HW +: HW] = b_h[i][HW-1:0];
        end
    end

    fsq_frame_seq #(
        .N_SETS(N_SETS), .AW(AW), .NBW(NBW), .HW(HW), .REQW(REQW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_all_sets(mode_all_sets),
        .start_set(start_set), .req_sets(req_sets),
        .set_base(set_base), .set_nbuf(set_nbuf), .set_bstep(set_bstep),
        .set_lstep(set_lstep), .set_height(set_height),
        .frame_start(frame_start), .line_done(line_done),
        .line_addr(line_addr), .line_valid(line_valid),
        .frame_done(frame_done), .last_base(last_base)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    bit          e_valid, e_done;
    logic [31:0] e_addr, e_last;
    bit          m_busy, m_fresh;
    int          m_rem, m_set, m_buf;

    function automatic int active_count();
        if (req_sets >= 1 && req_sets <= N_SETS) return int'(req_sets);
        return 1;
    endfunction

    function automatic int buf_count(int s);
        return (b_nbuf[s] == 0) ? 1 : int'(b_nbuf[s]);
    endfunction

    task automatic model_advance();
        if (m_buf + 1 >= buf_count(m_set)) begin
            m_buf = 0;
            if (mode_all_sets) m_set = (m_set + 1 >= active_count()) ? 0 : m_set + 1;
        end else begin
            m_buf = m_buf + 1;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid = 0; e_done = 0; e_addr = '0; e_last = 32'hFFFF_FFFF;
            m_busy = 0; m_fresh = 1; m_rem = 0; m_set = 0; m_buf = 0;
        end else begin
            e_done = 0;
            if (!m_busy && frame_start) begin
                int act;
                int ss;
                longint bb;
                act = active_count();
                ss  = (int'(start_set) < act) ? int'(start_set) : 0;
                if (m_fresh || m_set >= act || (!mode_all_sets && ss != m_set)) begin
                    m_set = ss;
                    m_buf = 0;
                end
                m_fresh = 0;
                if (buf_count(m_set) == 1) bb = longint'(b_base[m_set]);
                else bb = longint'(b_base[m_set]) + longint'(m_buf) * longint'(b_bstep[m_set]);
                e_last = bb[31:0];
                if (b_h[m_set] == 0) begin
                    e_done = 1;
                    model_advance();
                end else begin
                    m_busy = 1; e_valid = 1; e_addr = bb[31:0]; m_rem = int'(b_h[m_set]);
                end
            end else if (m_busy && line_done) begin
                if (m_rem == 1) begin
                    m_busy = 0; e_valid = 0; e_done = 1;
                    model_advance();
                end else begin
                    m_rem = m_rem - 1;
                    e_addr = e_addr + b_lstep[m_set];
                end
            end
        end
    end

    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            chk("R4 line_valid", 32'(line_valid), 32'(e_valid));
            chk("R4 frame_done", 32'(frame_done), 32'(e_done));
            chk("R10 last_base", last_base, e_last);
            if (e_valid) chk("R3 line_addr", line_addr, e_addr);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One frame: start, check first address, poke a stray start, consume lines
    task automatic do_frame(input logic [31:0] exp_base, input string tag, input bit zero_h);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (zero_h) begin
            chk({tag, " zero-height done"}, 32'(frame_done), 32'd1);
            chk({tag, " zero-height no line"}, 32'(line_valid), 32'd0);
            chk({tag, " base"}, last_base, exp_base);
            @(negedge clk);
            chk("R4 done drops", 32'(frame_done), 32'd0);
            return;
        end
        chk({tag, " valid"}, 32'(line_valid), 32'd1);
        chk({tag, " first line"}, line_addr, exp_base);
        chk({tag, " last_base"}, last_base, exp_base);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        while (line_valid) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            line_done = 1'b1;
            @(negedge clk);
            line_done = 1'b0;
        end
        @(negedge clk);
        chk("R2 stray start dropped", 32'(line_valid), 32'd0);
    endtask

    initial begin
        b_base[0] = 32'h0000_1000; b_nbuf[0] = 3; b_bstep[0] = 32'h100;  b_lstep[0] = 32'h10; b_h[0] = 4;
        b_base[1] = 32'h0000_8000; b_nbuf[1] = 1; b_bstep[1] = 32'hDEAD; b_lstep[1] = 32'h20; b_h[1] = 2;
        b_base[2] = 32'h0000_A000; b_nbuf[2] = 2; b_bstep[2] = 32'h400;  b_lstep[2] = 32'h4;  b_h[2] = 1;
        b_base[3] = 32'h0000_C000; b_nbuf[3] = 0; b_bstep[3] = 32'h55;   b_lstep[3] = 32'h8;  b_h[3] = 0;

        // Phase A: single-set order
        mode_all_sets = 1'b0; start_set = 2'd0; req_sets = 7'd2;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", 32'(line_valid), 32'd0);
        chk("R1 done", 32'(frame_done), 32'd0);
        chk("R1 last_base", last_base, 32'hFFFF_FFFF);
        compare_on = 1'b1;
        do_frame(32'h1000, "R2", 1'b0);
        do_frame(32'h1100, "R5 buffer1", 1'b0);
        do_frame(32'h1200, "R5 buffer2", 1'b0);
        do_frame(32'h1000, "R5 wrap", 1'b0);
        chk("R10 holds", last_base, 32'h1000);
        start_set = 2'd1;
        do_frame(32'h8000, "R6 switch", 1'b0);
        do_frame(32'h8000, "R5 single buffer", 1'b0);
        start_set = 2'd0;
        do_frame(32'h1000, "R6 back buffer0", 1'b0);

        // Phase B: all-sets order from set 2
        compare_on = 1'b0;
        mode_all_sets = 1'b1; start_set = 2'd2; req_sets = 7'd3;
        do_reset();
        compare_on = 1'b1;
        do_frame(32'hA000, "R9 first", 1'b0);
        do_frame(32'hA400, "R5 set2 buf1", 1'b0);
        do_frame(32'h1000, "R7 wrap to set0", 1'b0);
        do_frame(32'h1100, "R7 set0 buf1", 1'b0);
        do_frame(32'h1200, "R7 set0 buf2", 1'b0);
        do_frame(32'h8000, "R7 set1", 1'b0);
        do_frame(32'hA000, "R7 set2 again", 1'b0);

        // Phase C: illegal set counts
        compare_on = 1'b0;
        start_set = 2'd0; req_sets = 7'd9;
        do_reset();
        compare_on = 1'b1;
        do_frame(32'h1000, "R8 too many", 1'b0);
        do_frame(32'h1100, "R8 too many", 1'b0);
        do_frame(32'h1200, "R8 too many", 1'b0);
        do_frame(32'h1000, "R8 stays set0", 1'b0);
        req_sets = 7'd0;
        start_set = 2'd3;
        do_frame(32'h1100, "R8 zero and start clamp", 1'b0);

        // Phase D: zero-height set with zero buffer count
        compare_on = 1'b0;
        start_set = 2'd3; req_sets = 7'd4;
        do_reset();
        compare_on = 1'b1;
        do_frame(32'hC000, "R4", 1'b1);
        do_frame(32'h1000, "R7 after last set", 1'b0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule